// File: doc/BRIEF.md
# Three-Wire Control Port Slave

This block is the slave end of a three-wire microcontroller control bus. The bus has a clock line, a mode line and a data line. The pad is split into an input, an output and an output enable. When the mode line is low, an addressing byte selects the device and sets the kind of transfer. When the mode line is high, a command byte names a register, and then data moves into or out of a small bank of 16-bit configuration registers. The bank lives in the system clock domain, and its contents are presented there as a flat vector.

The three bus lines are brought into the system clock through synchronisers and edge detectors, so the system clock must run during any transfer. Bits are taken on each rising bus-clock edge. During a read, the slave puts each bit on the line after a falling edge, so the master can sample it on the next rising edge. A read first returns the prepared register address with a validity flag, then the register value, high byte first.

Top module: `tw_ctrl_slave`

## Requirements
- R1: Every byte is transferred least significant bit first. In address mode (mode low, eight clock pulses), byte bits 7..2 carry the device address and bits 1..0 carry the operation bits. The device answers to 6'b001000 when `addr_sel_i` is 0 and to 6'b101000 when it is 1.
- R2: Operation bits (bit1,bit0) = (1,0) select write or prepare-read, and (1,1) select read. The values (0,0) and (0,1) are ignored: no register changes and the data line is not driven.
- R3: An address byte with a foreign device address deselects the slave. Later data-mode bytes have no effect until the slave is addressed again.
- R4: In the first data-mode byte after a write/prepare selection, bit 0 is a flag (0 = write) and bits 7..1 are a register address. Each following pair of bytes (high byte first) writes that register. Addresses at or above NUM_REGS are not written.
- R5: A command byte with flag 1 records the register address for later reads and writes nothing.
- R6: A read shifts out 24 bits. The first byte holds the prepared address in bits 7..1, with bit 0 = 0 if the address is valid and 1 if it is invalid. Then the register's high byte and low byte follow; an invalid address returns zero. After the 24th bit the output enable is released.
- R7: The data output changes only after a falling bus-clock edge and stays stable through the master's rising-edge sample. The output enable is active only during the read phase with the mode line high.
- R8: After reset the interface ignores the bus until one rising bus-clock edge has arrived. That edge is consumed and carries no bit.
- R9: `cfg_regs_o` shows all registers, zero after reset. Register bits change only as a result of a completed write.
- R10: Once a command byte has been taken, later bytes in the same data phase are data, even when they look like command bytes. A new register address needs a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| addr_sel_i | input | 1 | Strap picking the device address |
| bus_clk_i | input | 1 | Bus clock, idles high |
| bus_mode_i | input | 1 | Bus mode line, low for address mode |
| bus_data_i | input | 1 | Bus data from the master |
| bus_data_o | output | 1 | Bus data to the master |
| bus_data_oe_o | output | 1 | Drive enable for the data pad |
| cfg_regs_o | output | NUM_REGS*16 | Register bank, register r at bits r*16 +: 16 |

## Verification
The hardest state to reach from the ports is the one just after reset, before the wake-up edge. A full write sent straight after reset must vanish, because its first clock edge only wakes the interface. The bench starts with exactly such a write and only then checks normal traffic. A second hard case is a data phase whose bytes look like command bytes. Directed sequences cover it and show that only the register named first is changed. Randomised writes, prepares and reads over valid and invalid addresses, with both strap values, are then checked against a bench model of the bank.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;
    localparam int BYTE_W     = 8;
    localparam int DEV_ADDR_W = 6;
    localparam int REG_ADDR_W = 7;
    localparam int DATA_W     = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SEL,
        ST_CMD,
        ST_WDATA,
        ST_RDATA
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_READ
    } op_e;

    typedef struct packed {
        logic [DEV_ADDR_W-1:0] dev;
        logic [1:0]            opbits;
    } addr_byte_t;

    typedef struct packed {
        logic [REG_ADDR_W-1:0] reg_addr;
        logic                  rd_flag;
    } cmd_byte_t;

    function automatic logic [DEV_ADDR_W-1:0] own_address(input logic sel);
        return sel ? 6'b101000 : 6'b001000;
    endfunction

    function automatic op_e decode_op(input logic [1:0] opbits);
        case (opbits)
            2'b10:   return OP_WRITE;
            2'b11:   return OP_READ;
            default: return OP_NONE;
        endcase
    endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [STAGES:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= {(STAGES+1){RST_VAL}};
        else     stage_q <= {stage_q[STAGES-1:0], async_i};
    end

    assign sync_o = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~stage_q[STAGES];
    assign fall_o = ~stage_q[STAGES-1] & stage_q[STAGES];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
    import tw_ctrl_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [REG_ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [REG_ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                          q <= '0;
                else if (wr_en && wr_addr == REG_ADDR_W'(r))      q <= wr_data;
            end
            assign regs_flat[r*DATA_W +: DATA_W] = q;
        end
    endgenerate

    always_comb begin
        rd_data  = '0;
        rd_valid = 1'b0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_addr == REG_ADDR_W'(r)) begin
                rd_data  = regs_flat[r*DATA_W +: DATA_W];
                rd_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tw_proto.sv
module tw_proto
    import tw_ctrl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dev_sel_i,
    input  logic                  data_s_i,
    input  logic                  clk_rise_i,
    input  logic                  clk_fall_i,
    input  logic                  mode_s_i,
    input  logic                  mode_rise_i,
    input  logic                  mode_fall_i,
    input  logic [DATA_W-1:0]     rd_data_i,
    input  logic                  rd_valid_i,
    output logic                  wr_en_o,
    output logic [REG_ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0]     wr_data_o,
    output logic [REG_ADDR_W-1:0] rd_addr_o,
    output logic                  sdo_o,
    output logic                  sdo_oe_o,
    output logic                  awake_o,
    output phase_e                phase_o
);
    localparam int         TX_BITS = 3 * BYTE_W;
    localparam logic [4:0] TX_LAST = 5'(TX_BITS);

    phase_e                phase_q;
    op_e                   op_q;
    logic                  awake_q;
    logic [2:0]            bit_q;
    logic [BYTE_W-1:0]     rx_q;
    logic [BYTE_W-1:0]     hi_q;
    logic                  odd_q;
    logic [4:0]            tx_q;
    logic [REG_ADDR_W-1:0] prep_q;

    logic [BYTE_W-1:0]     byte_in;
    logic                  byte_done;
    addr_byte_t            ab;
    cmd_byte_t             cb;
    logic [TX_BITS-1:0]    tx_vec;

    always_comb begin
        byte_in   = {data_s_i, rx_q[BYTE_W-1:1]};
        byte_done = (bit_q == 3'd7);
        ab        = addr_byte_t'(byte_in);
        cb        = cmd_byte_t'(byte_in);
        tx_vec    = {rd_data_i[7:0], rd_data_i[15:8], prep_q, ~rd_valid_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= ST_IDLE;
            op_q      <= OP_NONE;
            awake_q   <= 1'b0;
            bit_q     <= '0;
            rx_q      <= '0;
            hi_q      <= '0;
            odd_q     <= 1'b0;
            tx_q      <= '0;
            prep_q    <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            sdo_o     <= 1'b0;
            sdo_oe_o  <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            if (!awake_q) begin
                if (clk_rise_i) awake_q <= 1'b1;
            end else if (mode_fall_i) begin
                phase_q  <= ST_ADDR;
                bit_q    <= '0;
                sdo_oe_o <= 1'b0;
            end else if (mode_rise_i) begin
                bit_q    <= '0;
                tx_q     <= '0;
                odd_q    <= 1'b0;
                sdo_oe_o <= 1'b0;
                if (phase_q == ST_SEL && op_q == OP_WRITE)     phase_q <= ST_CMD;
                else if (phase_q == ST_SEL && op_q == OP_READ) phase_q <= ST_RDATA;
                else                                           phase_q <= ST_IDLE;
            end else if (clk_rise_i) begin
                rx_q  <= byte_in;
                bit_q <= bit_q + 3'd1;
                case (phase_q)
                    ST_ADDR: if (byte_done) begin
                        op_q <= decode_op(ab.opbits);
                        if (ab.dev == own_address(dev_sel_i) && decode_op(ab.opbits) != OP_NONE)
                            phase_q <= ST_SEL;
                        else
                            phase_q <= ST_IDLE;
                    end
                    ST_CMD: if (byte_done) begin
                        if (cb.rd_flag) begin
                            prep_q  <= cb.reg_addr;
                            phase_q <= ST_IDLE;
                        end else begin
                            wr_addr_o <= cb.reg_addr;
                            odd_q     <= 1'b0;
                            phase_q   <= ST_WDATA;
                        end
                    end
                    ST_WDATA: if (byte_done) begin
                        if (!odd_q) begin
                            hi_q  <= byte_in;
                            odd_q <= 1'b1;
                        end else begin
                            wr_en_o   <= 1'b1;
                            wr_data_o <= {hi_q, byte_in};
                            odd_q     <= 1'b0;
                        end
                    end
                    ST_RDATA: if (tx_q != TX_LAST) tx_q <= tx_q + 5'd1;
                    default: ;
                endcase
            end else if (clk_fall_i && phase_q == ST_RDATA && mode_s_i) begin
                if (tx_q != TX_LAST) begin
                    sdo_oe_o <= 1'b1;
                    sdo_o    <= tx_vec[tx_q];
                end else begin
                    sdo_oe_o <= 1'b0;
                end
            end
        end
    end

    assign rd_addr_o = prep_q;
    assign awake_o   = awake_q;
    assign phase_o   = phase_q;
endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
    import tw_ctrl_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       sys_clk,
    input  logic                       sys_rst,
    input  logic                       addr_sel_i,
    input  logic                       bus_clk_i,
    input  logic                       bus_mode_i,
    input  logic                       bus_data_i,
    output logic                       bus_data_o,
    output logic                       bus_data_oe_o,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs_o
);
    localparam int LINES = 3;

    logic [LINES-1:0] sync_v, rise_v, fall_v;
    logic             wr_en, rd_valid, awake;
    logic [REG_ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0]     wr_data, rd_data;
    phase_e           phase;
    logic             mode_s, clk_fall;

    tw_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) i_sync (
        .clk    (sys_clk),
        .rst    (sys_rst),
        .async_i({bus_clk_i, bus_mode_i, bus_data_i}),
        .sync_o (sync_v),
        .rise_o (rise_v),
        .fall_o (fall_v)
    );

    assign mode_s   = sync_v[1];
    assign clk_fall = fall_v[2];

    tw_proto i_proto (
        .clk        (sys_clk),
        .rst        (sys_rst),
        .dev_sel_i  (addr_sel_i),
        .data_s_i   (sync_v[0]),
        .clk_rise_i (rise_v[2]),
        .clk_fall_i (clk_fall),
        .mode_s_i   (mode_s),
        .mode_rise_i(rise_v[1]),
        .mode_fall_i(fall_v[1]),
        .rd_data_i  (rd_data),
        .rd_valid_i (rd_valid),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_addr_o  (rd_addr),
        .sdo_o      (bus_data_o),
        .sdo_oe_o   (bus_data_oe_o),
        .awake_o    (awake),
        .phase_o    (phase)
    );

    tw_regfile #(.NUM_REGS(NUM_REGS)) i_regs (
        .clk      (sys_clk),
        .rst      (sys_rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .regs_flat(cfg_regs_o)
    );
endmodule

// File: rtl/tw_ctrl_slave_chk.sv
module tw_ctrl_slave_chk
    import tw_ctrl_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       mode_s,
    input logic                       clk_fall,
    input logic                       awake,
    input phase_e                     phase,
    input logic                       wr_en,
    input logic                       sdo,
    input logic                       sdo_oe,
    input logic [NUM_REGS*DATA_W-1:0] regs
);
    AST_OE_OFF_AFTER_MODE_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_s) |=> !sdo_oe); // R7
    AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(clk_fall)); // R7
    AST_NO_WRITE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        !awake |-> !wr_en); // R8
    AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(regs)); // R9
    AST_WRITE_FROM_DATA_PHASE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(phase) == ST_WDATA); // R4
    AST_OE_IN_READ_PHASE: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> phase == ST_RDATA); // R6
endmodule

bind tw_ctrl_slave tw_ctrl_slave_chk #(.NUM_REGS(NUM_REGS)) i_chk (
    .clk     (sys_clk),
    .rst     (sys_rst),
    .mode_s  (mode_s),
    .clk_fall(clk_fall),
    .awake   (awake),
    .phase   (phase),
    .wr_en   (wr_en),
    .sdo     (bus_data_o),
    .sdo_oe  (bus_data_oe_o),
    .regs    (cfg_regs_o)
);

// File: tb/test_tw_ctrl_slave.sv
`timescale 1ns/1ps
module test_tw_ctrl_slave;
    localparam int NUM_REGS = 8;
    localparam int HALF     = 10;

    logic sys_clk = 1'b0;
    logic sys_rst = 1'b1;
    logic addr_sel = 1'b0;
    logic bclk = 1'b1, bmode = 1'b1, bdata = 1'b0;
    logic sdo, sdo_oe;
    logic [NUM_REGS*16-1:0] cfg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [15:0] model [NUM_REGS];

    always #2 sys_clk = ~sys_clk;

    tw_ctrl_slave #(.NUM_REGS(NUM_REGS)) i_tw_ctrl_slave (
        .sys_clk      (sys_clk),
        .sys_rst      (sys_rst),
        .addr_sel_i   (addr_sel),
        .bus_clk_i    (bclk),
        .bus_mode_i   (bmode),
        .bus_data_i   (bdata),
        .bus_data_o   (sdo),
        .bus_data_oe_o(sdo_oe),
        .cfg_regs_o   (cfg)
    );

    function automatic logic [5:0] dev_of(input logic sel);
        return sel ? 6'b101000 : 6'b001000;
    endfunction

    function automatic logic [7:0] first_byte(input logic [6:0] a);
        return {a, (int'(a) >= NUM_REGS)};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int r = 0; r < NUM_REGS; r++)
            chk(req, {16'h0, cfg[r*16 +: 16]}, {16'h0, model[r]});
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            bdata = b[i];
            bclk  = 1'b0;
            wait_cyc(HALF);
            bclk  = 1'b1;
            wait_cyc(HALF);
        end
    endtask

    task automatic addr_phase(input logic [5:0] dev, input logic [1:0] opb);
        bmode = 1'b0;
        wait_cyc(HALF);
        send_byte({dev, opb});
        bmode = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic read_byte(output logic [7:0] b, output logic ok);
        logic early;
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bclk = 1'b0;
            wait_cyc(HALF - 4);
            early = sdo;
            wait_cyc(4);
            b[i] = sdo;
            ok = ok & sdo_oe & (early == sdo);
            bclk = 1'b1;
            wait_cyc(HALF);
        end
    endtask

    task automatic do_write(input logic [5:0] dev, input logic [1:0] opb,
                            input logic [6:0] a, input logic [15:0] d);
        addr_phase(dev, opb);
        send_byte({a, 1'b0});
        send_byte(d[15:8]);
        send_byte(d[7:0]);
    endtask

    task automatic do_prepare(input logic [6:0] a);
        addr_phase(dev_of(addr_sel), 2'b10);
        send_byte({a, 1'b1});
    endtask

    task automatic do_read(input logic [6:0] a, input string req);
        logic [7:0] b0, b1, b2;
        logic ok0, ok1, ok2;
        logic [15:0] e;
        e = (int'(a) < NUM_REGS) ? model[a] : 16'h0;
        addr_phase(dev_of(addr_sel), 2'b11);
        read_byte(b0, ok0);
        read_byte(b1, ok1);
        read_byte(b2, ok2);
        chk({req, " R6 first byte"}, {24'h0, b0}, {24'h0, first_byte(a)});
        chk({req, " R6 data"}, {16'h0, b1, b2}, {16'h0, e});
        chk({req, " R7 drive stable"}, {31'h0, ok0 & ok1 & ok2}, 32'h1);
    endtask

    task automatic model_write(input logic [6:0] a, input logic [15:0] d);
        if (int'(a) < NUM_REGS) model[a] = d;
    endtask

    initial begin
        repeat (190000) @(posedge sys_clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic ok;
        void'($urandom(32'h5eed_0042));
        for (int r = 0; r < NUM_REGS; r++) model[r] = 16'h0;
        wait_cyc(5);
        sys_rst = 1'b0;
        wait_cyc(5);

        // R9: reset state
        check_bank("R9 reset bank");
        chk("R7 reset oe", {31'h0, sdo_oe}, 32'h0);

        // R8: first write after reset only wakes the port
        do_write(dev_of(0), 2'b10, 7'd1, 16'h1234);
        wait_cyc(HALF);
        check_bank("R8 pre-wake write ignored");

        // R1: normal write with strap 0
        do_write(dev_of(0), 2'b10, 7'd2, 16'hA55A);
        model_write(7'd2, 16'hA55A);
        wait_cyc(HALF);
        check_bank("R1 write strap0");

        // R3: foreign address, then re-addressed
        do_write(dev_of(1), 2'b10, 7'd3, 16'h3333);
        wait_cyc(HALF);
        check_bank("R3 foreign ignored");
        do_write(dev_of(0), 2'b10, 7'd3, 16'h0303);
        model_write(7'd3, 16'h0303);
        wait_cyc(HALF);
        check_bank("R3 reselected");

        // R2: unused operation bits
        do_write(dev_of(0), 2'b00, 7'd4, 16'h4444);
        do_write(dev_of(0), 2'b01, 7'd4, 16'h4545);
        wait_cyc(HALF);
        check_bank("R2 unused op ignored");
        chk("R2 no drive", {31'h0, sdo_oe}, 32'h0);

        // R10: bytes after command are data
        addr_phase(dev_of(0), 2'b10);
        send_byte({7'd5, 1'b0});
        send_byte(8'h06);
        send_byte(8'h07);
        send_byte(8'hBE);
        send_byte(8'hEF);
        model_write(7'd5, 16'hBEEF);
        wait_cyc(HALF);
        check_bank("R10 data not command");

        // R4: out-of-range write dropped
        do_write(dev_of(0), 2'b10, 7'd9, 16'h9999);
        wait_cyc(HALF);
        check_bank("R4 invalid write dropped");

        // R5 / R6: prepare and read back
        do_prepare(7'd2);
        wait_cyc(HALF);
        check_bank("R5 prepare writes nothing");
        do_read(7'd2, "R5 valid");
        do_prepare(7'd100);
        do_read(7'd100, "R6 invalid");

        // R6: release after 24 bits
        bclk = 1'b0;
        wait_cyc(HALF);
        chk("R6 released", {31'h0, sdo_oe}, 32'h0);
        bclk = 1'b1;
        wait_cyc(HALF);
        // R7: not driven in address mode
        bmode = 1'b0;
        wait_cyc(HALF);
        chk("R7 no drive in address mode", {31'h0, sdo_oe}, 32'h0);
        bmode = 1'b1;
        wait_cyc(HALF);

        // R1: strap 1
        addr_sel = 1'b1;
        wait_cyc(HALF);
        do_write(dev_of(1), 2'b10, 7'd6, 16'h6006);
        model_write(7'd6, 16'h6006);
        do_write(dev_of(0), 2'b10, 7'd6, 16'hDEAD);
        wait_cyc(HALF);
        check_bank("R1 strap1");

        // random mix
        for (int it = 0; it < 25; it++) begin
            logic [6:0] a;
            logic [15:0] d;
            addr_sel = 1'($urandom_range(0, 1));
            a = 7'($urandom_range(0, 11));
            d = 16'($urandom);
            wait_cyc(HALF);
            do_write(dev_of(addr_sel), 2'b10, a, d);
            model_write(a, d);
            do_prepare(a);
            do_read(a, "R4 random");
            check_bank("R9 random bank");
        end
        b = '0; ok = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule